// File: doc/BRIEF.md
# DMA Transfer Sequencer for a 4-bit Multiplexed Peripheral Bus

This block is the peripheral side of DMA cycles on a 4-bit multiplexed low-pin-count bus. It recognises a host start nibble while the frame strobe is low. It then samples three header nibbles: the cycle type, the channel with its terminal-count flag, and the transfer size. After that it moves one or two data bytes in the direction the cycle type selects. A verify cycle reaches the block coded exactly as a peripheral-to-memory transfer, and the block handles it the same way.

Each byte is followed by a status (SYNC) nibble that the block drives. The nibble tells the host one of three things: the transfer ends cleanly, it ends with an error, or the peripheral wants more data. The SYNC code is the only way the block signals the end of a transfer; it never does so by dropping a request line. The stored terminal-count flag is shown on the local side only with the last byte of the decoded size.

When configured for demand mode, a "more data" status on the final byte lets the next cycle be taken as a fresh grant whatever its channel field carries. In single mode every cycle must name the configured channel.

Top module: `lpcdma_seq`

## Requirements
- R1: After reset the block does not drive the bus (`lad_oe`=0), and `rx_valid`, `tx_take` and `tc_out` are all 0.
- R2: A clock with `frame_n`=0 and `lad_in`=0000 starts a cycle; the next nibble is the cycle type. Type bits [3:2]=10 mean DMA, and type bit 1 gives the direction (0 = host to peripheral, 1 = peripheral to host, which also covers verify). Any other type leaves the block idle and silent.
- R3: In the channel nibble, bits [2:0] are compared with `cfg_chan` and bit 3 is stored as the terminal-count flag. On a mismatch without a pending demand grant, the block never drives the bus and produces no local strobe.
- R4: Size nibble 0000 selects one byte and 0001 selects two bytes. Any other size leaves the block idle and silent.
- R5: Host-to-peripheral byte: the host sends the low nibble and then the high nibble in the two clocks after the size nibble, or after the previous byte's trailing turnaround. In the next clock `rx_valid`=1 with the assembled byte on `rx_data`.
- R6: Peripheral-to-host byte: `tx_take`=1 during the second clock of the turnaround before SYNC, and `tx_data` is captured at that clock's end. The byte is driven low nibble first in the two clocks right after SYNC.
- R7: Each byte has two undriven turnaround clocks before the SYNC clock and two undriven clocks at its end.
- R8: The SYNC nibble is chosen from `err_in` and `more_req` as sampled in the clock before SYNC. An error gives 1010 (last byte); otherwise more-data gives 1001; otherwise 0000 (last byte).
- R9: On a two-byte transfer, a first-byte SYNC of 0000 or 1010 ends the cycle. No second byte is moved and the block returns to idle.
- R10: `tc_out`=1 together with the byte strobe (`rx_valid` or `tx_take`) of the last byte of the decoded size, and only when the stored flag is 1. It stays 0 on every other byte.
- R11: With `cfg_demand`=1, a 1001 SYNC on the final byte makes the next channel nibble accepted regardless of its value. With `cfg_demand`=0 the channel must always match.
- R12: `frame_n`=0 during a cycle aborts it. If that clock also carries 0000, it is a new start; otherwise the block goes idle and stays silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Bus nibble as seen at the pins |
| lad_out | output | 4 | Nibble driven by the block |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| cfg_chan | input | CH_W | Configured DMA channel number |
| cfg_demand | input | 1 | 1 = demand mode, 0 = single mode |
| tx_data | input | 8 | Local byte to send to the host |
| tx_take | output | 1 | Local byte is consumed this clock |
| rx_data | output | 8 | Byte received from the host |
| rx_valid | output | 1 | `rx_data` holds a new byte |
| more_req | input | 1 | Peripheral wants more bytes |
| err_in | input | 1 | Peripheral reports an error on this byte |
| tc_out | output | 1 | Terminal count on the final byte |

## Verification
A wrong phase in the sequencer shows within one clock as a misplaced drive enable or strobe: SYNC or data appears one clock early or late, or turnaround clocks are driven. A corrupted stored size or byte index shows at the end of the first byte, either as a second byte that should not exist or as a missing one. A lost terminal-count flag or demand-grant flag stays hidden until that byte's strobe or the next cycle's header. The bench therefore checks every clock of every byte and chains cycles back to back, so that state left by one cycle is judged by the next.

// File: rtl/lpcdma_pkg.sv
package lpcdma_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int NNIB   = BYTE_W / NIB_W;

  localparam logic [NIB_W-1:0] NIB_START = 4'b0000;
  localparam logic [NIB_W-1:0] SY_DONE   = 4'b0000;
  localparam logic [NIB_W-1:0] SY_ERR    = 4'b1010;
  localparam logic [NIB_W-1:0] SY_MORE   = 4'b1001;

  typedef enum logic [3:0] {
    S_IDLE, S_CTYPE, S_CHAN, S_SIZE,
    S_DLO, S_DHI, S_TA1, S_TA2, S_SYNC, S_TB1, S_TB2
  } st_t;

  // Cycle type: bits [3:2] = 10 mark a DMA cycle.
  function automatic logic ct_is_dma(input logic [NIB_W-1:0] ct);
    return ct[3:2] == 2'b10;
  endfunction

  // Cycle type bit 1 set: peripheral sends data to the host.
  function automatic logic ct_is_write(input logic [NIB_W-1:0] ct);
    return ct[1];
  endfunction

  // Byte count of a size nibble; 0 means unsupported.
  function automatic logic [1:0] size_bytes(input logic [NIB_W-1:0] sz);
    case (sz)
      4'b0000: return 2'd1;
      4'b0001: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // Status code for one byte; error has priority over more-data.
  function automatic logic [NIB_W-1:0] sync_pick(input logic err, input logic more);
    if (err)       return SY_ERR;
    else if (more) return SY_MORE;
    else           return SY_DONE;
  endfunction
endpackage

// File: rtl/lpcdma_dpath.sv
module lpcdma_dpath
  import lpcdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  lad_in,
  input  logic [NNIB-1:0]   cap,
  input  logic              load,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic [NNIB-1:0]   drv,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [NIB_W-1:0]  tx_nib
);
  logic [BYTE_W-1:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic [NIB_W-1:0]  nib_mask [NNIB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
    end else begin
      for (int i = 0; i < NNIB; i++) begin
        if (cap[i]) rx_q[i*NIB_W +: NIB_W] <= lad_in;
      end
      if (load) tx_q <= tx_data;
    end
  end

  // One masked nibble per slot of the byte, ORed together below.
  genvar g;
  generate
    for (g = 0; g < NNIB; g++) begin : g_nib
      assign nib_mask[g] = {NIB_W{drv[g]}} & tx_q[g*NIB_W +: NIB_W];
    end
  endgenerate

  always_comb begin
    tx_nib = '0;
    for (int i = 0; i < NNIB; i++) tx_nib = tx_nib | nib_mask[i];
  end

  assign rx_byte = rx_q;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap == '0) |=> $stable(rx_q)); // R5
  AST_CAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap)); // R5
endmodule

// File: rtl/lpcdma_sync.sv
module lpcdma_sync
  import lpcdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             err_in,
  input  logic             more_in,
  input  logic             is_final,
  input  logic             demand,
  input  logic             clear,
  output logic [NIB_W-1:0] code_q,
  output logic             last_q,
  output logic             cont_q
);
  logic wants_more;
  assign wants_more = !err_in && more_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= SY_DONE;
      last_q <= 1'b0;
      cont_q <= 1'b0;
    end else if (sample) begin
      code_q <= sync_pick(err_in, more_in);
      last_q <= !wants_more;
      if (is_final && demand && wants_more) cont_q <= 1'b1;
    end else if (clear) begin
      cont_q <= 1'b0;
    end
  end

  AST_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && err_in) |=> (code_q == SY_ERR && last_q)); // R8
  AST_MORE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !err_in && more_in) |=> (code_q == SY_MORE && !last_q)); // R8
  AST_CONT_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cont_q) |-> $past(demand)); // R11
endmodule

// File: rtl/lpcdma_seq.sv
module lpcdma_seq
  import lpcdma_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [NIB_W-1:0]  lad_in,
  output logic [NIB_W-1:0]  lad_out,
  output logic              lad_oe,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic              cfg_demand,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_take,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              more_req,
  input  logic              err_in,
  output logic              tc_out
);
  localparam int TC_BIT = NIB_W - 1;

  st_t state, nxt;
  logic wr_q, tc_q, hit_q, two_q, idx_q;
  logic [NIB_W-1:0] code_q;
  logic last_q, cont_q;
  logic [NIB_W-1:0] tx_nib;
  logic [NNIB-1:0]  cap, drv;

  // Named events for the assertions and the sub-blocks.
  logic ev_start, ev_abort, ev_chan, ev_sample, final_w, chan_ok, size_ok;
  assign ev_start  = !frame_n && (lad_in == NIB_START);
  assign ev_abort  = !frame_n && (state != S_IDLE);
  assign ev_chan   = frame_n && (state == S_CHAN);
  assign ev_sample = frame_n && (state == S_TA2);
  assign final_w   = (idx_q == two_q);
  assign chan_ok   = (lad_in[CH_W-1:0] == cfg_chan) || cont_q;
  assign size_ok   = (size_bytes(lad_in) != 2'd0);

  always_comb begin
    nxt = state;
    if (!frame_n) begin
      nxt = ev_start ? S_CTYPE : S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:  nxt = S_IDLE;
        S_CTYPE: nxt = ct_is_dma(lad_in) ? S_CHAN : S_IDLE;
        S_CHAN:  nxt = S_SIZE;
        S_SIZE:  nxt = (hit_q && size_ok) ? (wr_q ? S_TA1 : S_DLO) : S_IDLE;
        S_DLO:   nxt = S_DHI;
        S_DHI:   nxt = wr_q ? S_TB1 : S_TA1;
        S_TA1:   nxt = S_TA2;
        S_TA2:   nxt = S_SYNC;
        S_SYNC:  nxt = wr_q ? S_DLO : S_TB1;
        S_TB1:   nxt = S_TB2;
        S_TB2:   nxt = (last_q || final_w) ? S_IDLE : (wr_q ? S_TA1 : S_DLO);
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      wr_q  <= 1'b0;
      tc_q  <= 1'b0;
      hit_q <= 1'b0;
      two_q <= 1'b0;
      idx_q <= 1'b0;
    end else begin
      state <= nxt;
      if (frame_n) begin
        case (state)
          S_CTYPE: wr_q <= ct_is_write(lad_in);
          S_CHAN: begin
            tc_q  <= lad_in[TC_BIT];
            hit_q <= chan_ok;
          end
          S_SIZE: begin
            two_q <= (size_bytes(lad_in) == 2'd2);
            idx_q <= 1'b0;
          end
          S_TB2: if (!(last_q || final_w)) idx_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // Nibble capture for host-to-peripheral bytes, drive select for the reverse.
  assign cap = {(state == S_DHI) && !wr_q, (state == S_DLO) && !wr_q};
  assign drv = {(state == S_DHI) &&  wr_q, (state == S_DLO) &&  wr_q};

  lpcdma_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .lad_in  (lad_in),
    .cap     (cap),
    .load    (tx_take),
    .tx_data (tx_data),
    .drv     (drv),
    .rx_byte (rx_data),
    .tx_nib  (tx_nib)
  );

  lpcdma_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (ev_sample),
    .err_in   (err_in),
    .more_in  (more_req),
    .is_final (final_w),
    .demand   (cfg_demand),
    .clear    (ev_chan),
    .code_q   (code_q),
    .last_q   (last_q),
    .cont_q   (cont_q)
  );

  assign lad_oe   = (state == S_SYNC) || (drv != '0);
  assign lad_out  = (state == S_SYNC) ? code_q : tx_nib;
  assign rx_valid = (state == S_TA1) && !wr_q;
  assign tx_take  = (state == S_TA2) &&  wr_q;
  assign tc_out   = tc_q && final_w && (rx_valid || tx_take);

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && lad_in != NIB_START) |=> (state == S_IDLE)); // R12
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> (state == S_CTYPE)); // R12
  AST_DRIVE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lad_oe |-> hit_q); // R3
  AST_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TB2 && frame_n && last_q) |=> (state == S_IDLE)); // R9
  AST_TC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |-> (rx_valid || tx_take)); // R10
  AST_SYNC_AFTER_TA: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SYNC) |-> ($past(state) == S_TA2)); // R7
  AST_SYNC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SYNC) |-> (lad_oe && (lad_out == SY_DONE || lad_out == SY_ERR
                                      || lad_out == SY_MORE))); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, tx_take, (state == S_SYNC)})); // R6
endmodule

// File: tb/sim_lpcdma_seq.sv
module sim_lpcdma_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic [3:0] lad_in = 4'h0;
  logic [3:0] lad_out;
  logic lad_oe;
  logic [2:0] cfg_chan = 3'd3;
  logic cfg_demand = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_take;
  logic [7:0] rx_data;
  logic rx_valid;
  logic more_req = 1'b0;
  logic err_in = 1'b0;
  logic tc_out;

  int n_chk = 0;
  int n_fail = 0;
  bit cont_m = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpcdma_seq u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
    .lad_out(lad_out), .lad_oe(lad_oe), .cfg_chan(cfg_chan),
    .cfg_demand(cfg_demand), .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .more_req(more_req),
    .err_in(err_in), .tc_out(tc_out)
  );

  function automatic logic [3:0] exp_sync(input bit e, input bit m);
    return e ? 4'b1010 : (m ? 4'b1001 : 4'b0000);
  endfunction

  function automatic int exp_nbytes(input logic [3:0] sz);
    if (sz == 4'd0) return 1;
    if (sz == 4'd1) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one bus clock, then settle just past the edge.
  task automatic step(input logic fr, input logic [3:0] nib);
    frame_n = fr;
    lad_in  = nib;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(req, {29'd0, lad_oe, rx_valid, tx_take}, 32'd0);
      step(1'b1, 4'($urandom));
    end
  endtask

  task automatic xact(input logic [3:0] ct, input logic [3:0] chn, input logic [3:0] sz,
                      input logic [7:0] d0, input logic [7:0] d1,
                      input bit m0, input bit m1, input bit e0, input bit e1);
    bit wr, hit, fin;
    int nb;
    logic [7:0] d;
    logic [3:0] code;
    step(1'b0, 4'h0);
    step(1'b1, ct);
    if (ct[3:2] != 2'b10) begin
      quiet(6, "R2");
      return;
    end
    wr = ct[1];
    step(1'b1, chn);
    hit = (chn[2:0] == cfg_chan) || cont_m;
    cont_m = 1'b0;
    nb = exp_nbytes(sz);
    step(1'b1, sz);
    if (!hit) begin
      quiet(12, "R3");
      return;
    end
    if (nb == 0) begin
      quiet(8, "R4");
      return;
    end
    for (int i = 0; i < nb; i++) begin
      d = (i == 0) ? d0 : d1;
      more_req = (i == 0) ? m0 : m1;
      err_in   = (i == 0) ? e0 : e1;
      code = exp_sync(err_in, more_req);
      fin = (i == nb - 1);
      if (wr) begin
        chk("R7 ta1", {31'd0, lad_oe}, 32'd0);
        step(1'b1, 4'($urandom));
        chk("R6 take", {31'd0, tx_take}, 32'd1);
        chk("R10 tc", {31'd0, tc_out}, {31'd0, chn[3] & fin});
        tx_data = d;
        step(1'b1, 4'($urandom));
        chk("R8 sync", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, code});
        step(1'b1, 4'($urandom));
        chk("R6 lo", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, d[3:0]});
        step(1'b1, 4'($urandom));
        chk("R6 hi", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, d[7:4]});
        step(1'b1, 4'($urandom));
        chk("R7 tb1", {31'd0, lad_oe}, 32'd0);
        step(1'b1, 4'($urandom));
        chk("R7 tb2", {31'd0, lad_oe}, 32'd0);
        step(1'b1, 4'($urandom));
      end else begin
        chk("R5 lo", {30'd0, lad_oe, rx_valid}, 32'd0);
        step(1'b1, d[3:0]);
        step(1'b1, d[7:4]);
        chk("R5 rx", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, d});
        chk("R10 tc", {31'd0, tc_out}, {31'd0, chn[3] & fin});
        step(1'b1, 4'($urandom));
        chk("R7 ta2", {31'd0, lad_oe}, 32'd0);
        step(1'b1, 4'($urandom));
        chk("R8 sync", {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, code});
        step(1'b1, 4'($urandom));
        chk("R7 tb1", {31'd0, lad_oe}, 32'd0);
        step(1'b1, 4'($urandom));
        chk("R7 tb2", {31'd0, lad_oe}, 32'd0);
        step(1'b1, 4'($urandom));
      end
      if (code != 4'b1001 && !fin) begin
        quiet(10, "R9");
        break;
      end
      if (fin && code == 4'b1001 && cfg_demand) cont_m = 1'b1;
    end
    chk("R2 idle", {30'd0, lad_oe, rx_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] ct, chn, sz;
    int r;
    void'($urandom(32'h5eed1));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {28'd0, lad_oe, rx_valid, tx_take, tc_out}, 32'd0);
    rst_n = 1'b1;
    step(1'b1, 4'h0);
    chk("R1 after", {28'd0, lad_oe, rx_valid, tx_take, tc_out}, 32'd0);

    // Directed: single-byte read, TC set, clean end.
    xact(4'b1000, {1'b1, 3'd3}, 4'd0, 8'hA5, 8'h00, 0, 0, 0, 0);
    // Two-byte write, TC only on second byte.
    xact(4'b1010, {1'b1, 3'd3}, 4'd1, 8'h3C, 8'hE1, 1, 0, 0, 0);
    // Two-byte read ended early by error on first byte: no TC, no second byte.
    xact(4'b1000, {1'b1, 3'd3}, 4'd1, 8'h96, 8'h69, 0, 0, 1, 0);
    // Two-byte write ended early by clean end.
    xact(4'b1010, {1'b1, 3'd3}, 4'd1, 8'h5A, 8'h11, 0, 0, 0, 0);
    // Channel mismatch and bad size.
    xact(4'b1000, {1'b0, 3'd5}, 4'd0, 8'h12, 8'h00, 0, 0, 0, 0);
    xact(4'b1010, {1'b0, 3'd3}, 4'd3, 8'h12, 8'h00, 0, 0, 0, 0);
    // Non-DMA cycle type.
    xact(4'b0000, {1'b0, 3'd3}, 4'd0, 8'h12, 8'h00, 0, 0, 0, 0);

    // R11: demand grant lets a foreign channel through once.
    cfg_demand = 1'b1;
    xact(4'b1010, {1'b0, 3'd3}, 4'd0, 8'h77, 8'h00, 1, 0, 0, 0);
    xact(4'b1000, {1'b0, 3'd6}, 4'd0, 8'hC3, 8'h00, 0, 0, 0, 0);
    xact(4'b1000, {1'b0, 3'd6}, 4'd0, 8'hC3, 8'h00, 0, 0, 0, 0);
    // R11: single mode never grants on a foreign channel.
    cfg_demand = 1'b0;
    xact(4'b1010, {1'b0, 3'd3}, 4'd0, 8'h88, 8'h00, 1, 0, 0, 0);
    xact(4'b1010, {1'b0, 3'd1}, 4'd0, 8'h99, 8'h00, 0, 0, 0, 0);

    // R12: abort without start, then abort that restarts.
    step(1'b0, 4'h0);
    step(1'b1, 4'b1000);
    step(1'b1, {1'b0, 3'd3});
    step(1'b0, 4'h5);
    quiet(10, "R12");
    step(1'b0, 4'h0);
    step(1'b1, 4'b1010);
    step(1'b1, {1'b0, 3'd3});
    cont_m = 1'b0;
    xact(4'b1000, {1'b1, 3'd3}, 4'd0, 8'h4D, 8'h00, 0, 0, 0, 0);

    // Random mix.
    for (int t = 0; t < 300; t++) begin
      if (t % 50 == 0) cfg_demand = 1'($urandom);
      r = $urandom % 10;
      ct = (r < 4) ? 4'b1000 : (r < 8) ? 4'b1010 : (r < 9) ? 4'b1011 : 4'b0010;
      chn[3] = 1'($urandom);
      chn[2:0] = ($urandom % 4 != 0) ? cfg_chan : 3'($urandom);
      r = $urandom % 10;
      sz = (r < 4) ? 4'd0 : (r < 9) ? 4'd1 : 4'd2;
      xact(ct, chn, sz, 8'($urandom), 8'($urandom),
           ($urandom % 3) != 0, 1'($urandom), ($urandom % 6) == 0, ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule